// File: doc/BRIEF.md
# Controller Command Sequencer

This block sits behind the host's command byte and walks a network controller through its management states: uninitialized (after reset), OFFLINE and IDLE. Each 8-bit opcode is checked against the current state. A legal opcode is accepted and turned into one-cycle action strobes to the receive/transmit machinery. An illegal opcode is dropped and an error flag is set. The block also holds the bus-width choice, the table function code and the mode bits with their reset defaults.

Completion comes back on one of two paths. The reset command and the function-code load report through the semaphore byte: 0xFE while the command runs, 0xFF when it is finished. Every other command reports through a done flag with a status word, and that flag can also raise a command-complete interrupt. The self-test and table fetch behind initialization are outside the block and are reached through a request/acknowledge handshake.

Top module: `cmd_seq`

## Requirements
- R1: After hardware reset the outputs are: state 0 (uninitialized), semaphore 0xFF, bus16 0, init_fc 0, modes equal to the default (only bit HLEN_BIT set), and busy, done, cmd_err, severe_irq, init_req and all strobes at 0. State codes: 0 uninitialized, 1 OFFLINE, 2 IDLE.
- R2: Opcode 0xFF (reset command) is accepted in any state, even while busy or in severe error. After the accepting edge the semaphore is 0xFE. For one cycle rxtx_rst, zero_trt, zero_isw0 and clr_ring pulse. Modes return to the default, bus16 goes to 0, severe_irq clears, init_req drops and the state becomes 0. RST_CYCLES edges after acceptance, the semaphore becomes 0xFF and busy falls.
- R3: Opcodes 0xD0/0xD1 (function-code load) are legal only in state 0. Bit 0 of the opcode sets bus16, and cmd_data[3:0] is captured into init_fc. The semaphore is 0xFE for one cycle, then 0xFF. The done flag stays 0.
- R4: Opcode 0xC7 (initialize) is legal only in state 0. It raises init_req until init_ack. On an acknowledge without fault, done is set, status becomes 0x0001 and the state becomes 1. On an acknowledge with init_fail, done is set, status becomes 0x0011 and the state stays 0.
- R5: If init_bus_err is high with init_ack, severe_irq is set and done stays 0. While severe_irq is high, every opcode except 0xFF is rejected.
- R6: Opcode 0xF8 (offline) is legal in states 1 and 2. On acceptance, clr_send_pend, rxtx_rst and clr_ring pulse. One edge later, done is set, status is 0x0001 and the state is 1.
- R7: Opcode 0xF0 (idle) is legal only in state 1. On acceptance, clr_send_pend, rxtx_rst, zero_trt, zero_txfault, set_noise and set_no_succ pulse. One edge later, rx_enable pulses, done is set, status is 0x0001 and the state is 2.
- R8: Some opcodes are rejected: a reserved opcode, an opcode not legal in the current state, or any non-reset opcode while busy. A rejected opcode leaves state, semaphore, bus16 and init_fc unchanged and sets cmd_err. The next accepted opcode clears cmd_err.
- R9: irq equals irq_en AND a completion flag. That flag is set together with done and cleared, along with done, when the next opcode is accepted.
- R10: busy is high from the accepting edge until completion, and the semaphore reads 0xFE while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Opcode write strobe |
| cmd_op | input | 8 | Opcode |
| cmd_data | input | 8 | Data register byte 0 |
| irq_en | input | 1 | Command-complete interrupt enable |
| init_ack | input | 1 | Initialization/self-test finished |
| init_fail | input | 1 | Self-test failed (with init_ack) |
| init_bus_err | input | 1 | Bus/address error during initialization (with init_ack) |
| semaphore | output | 8 | 0xFE busy/accepted, 0xFF ready |
| state | output | 2 | 0 uninitialized, 1 OFFLINE, 2 IDLE |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | Last opcode rejected |
| bus16 | output | 1 | 1 = 16-bit bus, 0 = 8-bit |
| init_fc | output | FC_W | Table function code |
| modes | output | MODE_W | Mode bits |
| done | output | 1 | Status word valid |
| status | output | STAT_W | Completion status |
| irq | output | 1 | Command-complete interrupt |
| severe_irq | output | 1 | Severe error interrupt |
| init_req | output | 1 | Initialization request |
| rxtx_rst | output | 1 | Strobe: reset receive and transmit machines |
| rx_enable | output | 1 | Strobe: enable receive machine |
| clr_send_pend | output | 1 | Strobe: clear send-pending flag |
| clr_ring | output | 1 | Strobe: drop in-ring and successor-known flags |
| zero_trt | output | 1 | Strobe: zero rotation timer |
| zero_isw0 | output | 1 | Strobe: zero interrupt status word 0 |
| zero_txfault | output | 1 | Strobe: zero transmitter fault count |
| set_noise | output | 1 | Strobe: set noise-expected |
| set_no_succ | output | 1 | Strobe: set no-successor |

## Verification
The bench builds the block with RST_CYCLES = 3, MODE_W = 24 and HLEN_BIT = 5. The short reset window lets a second opcode land while the reset command is still running, which exercises the rejection of commands during busy. The nonzero HLEN position makes the default mode value distinguishable from all-zero. Random opcode streams, including reserved bytes, faulty self-test results and bus errors, drive the block through every state pair.

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int FC_W = 4,
  parameter int STAT_W = 16,
  parameter int MODE_W = 24,
  parameter int HLEN_BIT = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              irq_en,
  input  logic              init_ack,
  input  logic              init_fail,
  input  logic              init_bus_err,
  output logic [7:0]        semaphore,
  output logic [1:0]        state,
  output logic              busy,
  output logic              cmd_err,
  output logic              bus16,
  output logic [FC_W-1:0]   init_fc,
  output logic [MODE_W-1:0] modes,
  output logic              done,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              severe_irq,
  output logic              init_req,
  output logic              rxtx_rst,
  output logic              rx_enable,
  output logic              clr_send_pend,
  output logic              clr_ring,
  output logic              zero_trt,
  output logic              zero_isw0,
  output logic              zero_txfault,
  output logic              set_noise,
  output logic              set_no_succ
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [MODE_W-1:0] MODE_DEF = MODE_W'(1) << HLEN_BIT;
  localparam logic [1:0] S_UNINIT = 2'd0, S_OFF = 2'd1, S_IDLE = 2'd2;
  localparam logic [STAT_W-1:0] ST_OK = STAT_W'(16'h0001), ST_BAD = STAT_W'(16'h0011);

  typedef enum logic [2:0] {K_RST, K_LFC, K_INI, K_OFF, K_IDL} kind_t;

  kind_t kind, new_kind;
  logic [CW-1:0] cnt;
  logic cc;

  wire is_rst = cmd_op == 8'hFF;
  wire is_lfc = cmd_op[7:1] == 7'h68;
  wire is_ini = cmd_op == 8'hC7;
  wire is_off = cmd_op == 8'hF8;
  wire is_idl = cmd_op == 8'hF0;
  wire free = !busy && !severe_irq;
  wire legal = is_rst || (free && (((is_lfc || is_ini) && state == S_UNINIT) ||
                                   (is_off && state != S_UNINIT) ||
                                   (is_idl && state == S_OFF)));
  wire acc = cmd_valid && legal;

  assign irq = cc && irq_en;

  always_comb begin
    if (is_rst)      new_kind = K_RST;
    else if (is_lfc) new_kind = K_LFC;
    else if (is_ini) new_kind = K_INI;
    else if (is_off) new_kind = K_OFF;
    else             new_kind = K_IDL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      semaphore <= 8'hFF; state <= S_UNINIT; busy <= 1'b0; cmd_err <= 1'b0;
      bus16 <= 1'b0; init_fc <= '0; modes <= MODE_DEF; done <= 1'b0;
      status <= '0; cc <= 1'b0; severe_irq <= 1'b0; init_req <= 1'b0;
      kind <= K_RST; cnt <= '0;
      rxtx_rst <= 1'b0; rx_enable <= 1'b0; clr_send_pend <= 1'b0; clr_ring <= 1'b0;
      zero_trt <= 1'b0; zero_isw0 <= 1'b0; zero_txfault <= 1'b0;
      set_noise <= 1'b0; set_no_succ <= 1'b0;
    end else begin
      rxtx_rst <= 1'b0; rx_enable <= 1'b0; clr_send_pend <= 1'b0; clr_ring <= 1'b0;
      zero_trt <= 1'b0; zero_isw0 <= 1'b0; zero_txfault <= 1'b0;
      set_noise <= 1'b0; set_no_succ <= 1'b0;
      if (acc) begin
        busy <= 1'b1; semaphore <= 8'hFE; done <= 1'b0; cc <= 1'b0;
        cmd_err <= 1'b0; kind <= new_kind;
        case (new_kind)
          K_RST: begin
            modes <= MODE_DEF; bus16 <= 1'b0; severe_irq <= 1'b0; init_req <= 1'b0;
            state <= S_UNINIT; cnt <= CW'(RST_CYCLES - 1);
            rxtx_rst <= 1'b1; zero_trt <= 1'b1; zero_isw0 <= 1'b1; clr_ring <= 1'b1;
          end
          K_LFC: begin
            bus16 <= cmd_op[0]; init_fc <= cmd_data[FC_W-1:0];
          end
          K_INI: init_req <= 1'b1;
          K_OFF: begin
            clr_send_pend <= 1'b1; rxtx_rst <= 1'b1; clr_ring <= 1'b1;
          end
          default: begin
            clr_send_pend <= 1'b1; rxtx_rst <= 1'b1; zero_trt <= 1'b1;
            zero_txfault <= 1'b1; set_noise <= 1'b1; set_no_succ <= 1'b1;
          end
        endcase
      end else begin
        if (cmd_valid) cmd_err <= 1'b1;
        if (busy) begin
          case (kind)
            K_RST: begin
              if (cnt == '0) begin semaphore <= 8'hFF; busy <= 1'b0; end
              else cnt <= cnt - 1'b1;
            end
            K_LFC: begin semaphore <= 8'hFF; busy <= 1'b0; end
            K_INI: if (init_ack) begin
              init_req <= 1'b0; busy <= 1'b0;
              if (init_bus_err) severe_irq <= 1'b1;
              else begin
                done <= 1'b1; cc <= 1'b1;
                status <= init_fail ? ST_BAD : ST_OK;
                if (!init_fail) state <= S_OFF;
              end
            end
            K_OFF: begin
              busy <= 1'b0; done <= 1'b1; cc <= 1'b1; status <= ST_OK; state <= S_OFF;
            end
            default: begin
              busy <= 1'b0; done <= 1'b1; cc <= 1'b1; status <= ST_OK; state <= S_IDLE;
              rx_enable <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

module cmd_seq_props #(
  parameter int MODE_W = 24,
  parameter int HLEN_BIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_op,
  input logic [7:0]        semaphore,
  input logic [1:0]        state,
  input logic              busy,
  input logic              cmd_err,
  input logic              bus16,
  input logic [MODE_W-1:0] modes,
  input logic              done,
  input logic              severe_irq,
  input logic              rxtx_rst,
  input logic              rx_enable
);
  assert_sem_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    semaphore == 8'hFE || semaphore == 8'hFF);
  assert_busy_sem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> semaphore == 8'hFE);
  assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
  assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'hFF |=> busy && !bus16 && !severe_irq && rxtx_rst &&
    state == 2'd0 && modes == (MODE_W'(1) << HLEN_BIT));
  assert_rx_after_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |-> $past(rxtx_rst) && state == 2'd2);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_severe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    severe_irq && !(cmd_valid && cmd_op == 8'hFF) |=> severe_irq);
  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'hF0 && state == 2'd0 |=> cmd_err && state == 2'd0);
endmodule

bind cmd_seq cmd_seq_props #(.MODE_W(MODE_W), .HLEN_BIT(HLEN_BIT)) u_props (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .semaphore(semaphore), .state(state), .busy(busy), .cmd_err(cmd_err),
  .bus16(bus16), .modes(modes), .done(done), .severe_irq(severe_irq),
  .rxtx_rst(rxtx_rst), .rx_enable(rx_enable));

// File: tb/cmd_seq_test.sv
module cmd_seq_test;
  localparam int RC = 3;
  localparam int MW = 24;
  localparam int HB = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, irq_en = 1'b0, init_ack = 1'b0, init_fail = 1'b0, init_bus_err = 1'b0;
  logic [7:0] cmd_op = 8'h00, cmd_data = 8'h00;
  logic [7:0] semaphore; logic [1:0] state; logic busy, cmd_err, bus16, done, irq, severe_irq, init_req;
  logic [3:0] init_fc; logic [MW-1:0] modes; logic [15:0] status;
  logic rxtx_rst, rx_enable, clr_send_pend, clr_ring, zero_trt, zero_isw0, zero_txfault, set_noise, set_no_succ;

  cmd_seq #(.FC_W(4), .STAT_W(16), .MODE_W(MW), .HLEN_BIT(HB), .RST_CYCLES(RC)) uut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_st = 0; logic m_sev = 0, m_bus = 0; logic [3:0] m_fc = 0; logic [7:0] m_sem = 8'hFF;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic bit legal(input logic [7:0] op);
    if (op == 8'hFF) return 1;
    if (m_sev) return 0;
    if (op[7:1] == 7'h68 || op == 8'hC7) return m_st == 0;
    if (op == 8'hF8) return m_st != 0;
    if (op == 8'hF0) return m_st == 1;
    return 0;
  endfunction

  task automatic do_cmd(input logic [7:0] op, input logic [7:0] d, input bit fl, input bit be);
    bit lg = legal(op);
    @(negedge clk); cmd_op = op; cmd_data = d; cmd_valid = 1;
    @(posedge clk); #1 cmd_valid = 0;
    if (!lg) begin
      chk(cmd_err == 1, "R8 err", cmd_err, 1);
      chk(state == m_st && semaphore == m_sem, "R8 state/sem", {state, semaphore}, {m_st, m_sem});
      chk(bus16 == m_bus && init_fc == m_fc, "R8 cfg", {bus16, init_fc}, {m_bus, m_fc});
      return;
    end
    chk(busy && semaphore == 8'hFE && !cmd_err, "R10 accept", {busy, semaphore}, 9'h1FE);
    chk(rxtx_rst == (op == 8'hFF || op == 8'hF8 || op == 8'hF0), "R2/R6/R7 rxtx_rst", rxtx_rst, 0);
    chk(clr_ring == (op == 8'hFF || op == 8'hF8), "R2/R6 clr_ring", clr_ring, 0);
    chk(zero_trt == (op == 8'hFF || op == 8'hF0), "R2/R7 zero_trt", zero_trt, 0);
    chk(!done && !irq, "R9 done cleared", done, 0);
    m_sem = 8'hFE;
    if (op == 8'hFF) begin
      chk(zero_isw0 && modes == MW'(32'h20), "R2 defaults", modes, 32'h20);
      repeat (RC - 1) @(posedge clk); #1;
      chk(busy && semaphore == 8'hFE, "R10 reset busy", semaphore, 8'hFE);
      @(posedge clk); #1;
      m_st = 0; m_bus = 0; m_sev = 0; m_sem = 8'hFF;
      chk(!busy && semaphore == 8'hFF && state == 0 && !severe_irq && !bus16, "R2 reset done", semaphore, 8'hFF);
    end else if (op[7:1] == 7'h68) begin
      @(posedge clk); #1;
      m_bus = op[0]; m_fc = d[3:0]; m_sem = 8'hFF;
      chk(semaphore == 8'hFF && !busy && !done, "R3 sem", semaphore, 8'hFF);
      chk(bus16 == m_bus && init_fc == m_fc, "R3 cfg", {bus16, init_fc}, {m_bus, m_fc});
    end else if (op == 8'hC7) begin
      chk(init_req == 1, "R4 req", init_req, 1);
      repeat (2) @(posedge clk);
      @(negedge clk); init_ack = 1; init_fail = fl; init_bus_err = be;
      @(posedge clk); #1 init_ack = 0; init_fail = 0; init_bus_err = 0;
      if (be) begin
        m_sev = 1;
        chk(severe_irq && !done && !busy, "R5 severe", severe_irq, 1);
      end else begin
        if (!fl) m_st = 1;
        chk(done && status == (fl ? 16'h0011 : 16'h0001), "R4 status", status, fl ? 16'h11 : 16'h1);
        chk(state == m_st && !init_req, "R4 state", state, m_st);
        chk(irq == irq_en, "R9 irq", irq, irq_en);
      end
    end else begin
      if (op == 8'hF0) chk(set_noise && set_no_succ && zero_txfault && !rx_enable, "R7 strobes", set_noise, 1);
      else chk(clr_send_pend && !zero_txfault, "R6 strobes", clr_send_pend, 1);
      @(posedge clk); #1;
      m_st = (op == 8'hF0) ? 2 : 1;
      chk(done && status == 16'h0001 && state == m_st, "R6/R7 done", state, m_st);
      chk(rx_enable == (op == 8'hF0), "R7 rx_enable", rx_enable, op == 8'hF0);
      chk(irq == irq_en, "R9 irq", irq, irq_en);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++; $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    #12 rst_n = 1; #1;
    chk(state == 0 && semaphore == 8'hFF && !bus16 && init_fc == 0, "R1 reset", semaphore, 8'hFF);
    chk(modes == MW'(32'h20) && !busy && !done && !cmd_err && !severe_irq && !init_req && !rxtx_rst,
        "R1 flags", modes, 32'h20);
    do_cmd(8'hF0, 0, 0, 0);
    do_cmd(8'hD1, 8'hA5, 0, 0);
    irq_en = 1;
    do_cmd(8'hC7, 0, 1, 0);
    do_cmd(8'hC7, 0, 0, 0);
    do_cmd(8'hD0, 8'h03, 0, 0);
    do_cmd(8'hF0, 0, 0, 0);
    irq_en = 0;
    do_cmd(8'hF8, 0, 0, 0);
    do_cmd(8'h42, 0, 0, 0);
    @(negedge clk); cmd_op = 8'hFF; cmd_valid = 1;
    @(negedge clk); cmd_op = 8'hF8;
    @(posedge clk); #1 cmd_valid = 0;
    chk(cmd_err && busy && state == 0, "R8 busy reject", cmd_err, 1);
    repeat (RC) @(posedge clk); #1;
    m_st = 0; m_bus = 0; m_sev = 0; m_sem = 8'hFF;
    chk(semaphore == 8'hFF && !busy, "R2 after busy", semaphore, 8'hFF);
    do_cmd(8'hC7, 0, 0, 1);
    do_cmd(8'hF8, 0, 0, 0);
    do_cmd(8'hFF, 0, 0, 0);
    chk(!severe_irq, "R5 cleared", severe_irq, 0);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      case ($urandom % 9)
        0: op = 8'hFF; 1: op = 8'hC7; 2: op = 8'hF8; 3: op = 8'hF0;
        4: op = 8'hD0; 5: op = 8'hD1; 6: op = 8'hC7;
        default: op = 8'($urandom);
      endcase
      irq_en = 1'($urandom);
      do_cmd(op, 8'($urandom), ($urandom % 3) == 0, ($urandom % 10) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule